// File: doc/BRIEF.md
# Interrupt Source Pending Tracker

This block keeps the per-source bookkeeping of a multi-CPU interrupt controller. For every interrupt id it holds an enable bit, a trigger-type bit (edge or level), a delivery-model bit (one-of-N or each-of-N), a CPU target mask, the sampled state of the source's input line, and one pending bit per CPU. The block does not decode registers or pick priorities. The register decode and the acknowledge/end-of-interrupt logic around it deliver single-cycle strobes that carry a source id and, where it matters, a CPU number. The block folds these strobes and the external interrupt lines into the stored state.

The outputs are the per-CPU pending matrix and the enable vector, which a priority arbiter reads. A one-cycle update pulse tells the arbiter to re-evaluate. Ids 0 to 31 are internal or per-CPU sources and have no input line. External line n drives id n+32. Several strobes may target the same id in one cycle, and they are merged so that any setting action wins over any clearing action.

Top module: `irq_pend_tracker`

## Requirements
- R1: External line n (bit n of `ext_line`) belongs to source id n+32. Ids 0 to 31 have no line, and their stored level is always low.
- R2: If a line's value equals the stored level of its source and no strobe addresses that source, the source's state is unchanged and `upd_o` stays low in the next cycle.
- R3: On a rising line, the source's level goes high. Pending is set on the CPUs of its target mask only if the source is edge-triggered (trigger bit 1) or already enabled.
- R4: On a falling line, only the level goes low. The pending bits of that source are kept.
- R5: An enable-set strobe on a level-triggered source whose level is high after this cycle's line event sets pending. The mask is the writing CPU (`wr_cpu`) for ids below 32 and the target mask for other ids.
- R6: An acknowledge clears pending on every CPU when the model bit is 1 (one-of-N). When the model bit is 0 it clears pending only on the acknowledging CPU.
- R7: An end-of-interrupt from CPU c sets pending for c again if the source is level-triggered, enabled, its level is high, and c is in its target mask.
- R8: After reset, every bit of state is 0 except that ids 0 to 15 are enabled and edge-triggered.
- R9: An enable-clear strobe on ids 0 to 15 has no effect.
- R10: When a setting action and a clearing action reach the same bit in one cycle, the set wins. This covers enable-set against enable-clear, and a pending set against an acknowledge or a software clear.
- R11: `upd_o` is high for exactly the one cycle after any stored state has changed, and low otherwise.
- R12: A software pending-set marks the writing CPU for ids below 32 and the target mask otherwise. A software pending-clear clears every CPU.
- R13: A configuration strobe loads the trigger bit (1 = edge) and the model bit (1 = one-of-N). A target strobe loads the CPU mask, where bit c means CPU c. Pending for CPU c and id i appears at `pend_o[c*NUM_SRC+i]`, and enable for id i at `en_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_line | input | NUM_SRC-32 | External interrupt lines, line n for id n+32 |
| wr_cpu | input | CPU_W | CPU issuing the enable-set or software pending-set |
| en_set_vld | input | 1 | Enable-set strobe |
| en_set_id | input | ID_W | Source id for enable-set |
| en_clr_vld | input | 1 | Enable-clear strobe |
| en_clr_id | input | ID_W | Source id for enable-clear |
| cfg_vld | input | 1 | Trigger/model configuration strobe |
| cfg_id | input | ID_W | Source id for configuration |
| cfg_edge | input | 1 | New trigger bit, 1 = edge |
| cfg_model | input | 1 | New model bit, 1 = one-of-N |
| tgt_vld | input | 1 | Target mask strobe |
| tgt_id | input | ID_W | Source id for target mask |
| tgt_mask | input | NUM_CPU | New target mask |
| pset_vld | input | 1 | Software pending-set strobe |
| pset_id | input | ID_W | Source id for pending-set |
| pclr_vld | input | 1 | Software pending-clear strobe |
| pclr_id | input | ID_W | Source id for pending-clear |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged source id |
| ack_cpu | input | CPU_W | Acknowledging CPU |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Completed source id |
| eoi_cpu | input | CPU_W | Completing CPU |
| pend_o | output | NUM_CPU*NUM_SRC | Pending matrix, bit c*NUM_SRC+i |
| en_o | output | NUM_SRC | Enable per source |
| upd_o | output | 1 | One-cycle change pulse to the arbiter |

## Verification
The collision of interest is an acknowledge or software pending-clear landing in the same cycle as a pending-setting event on the same source, such as a software set, an end-of-interrupt re-mark, or a rising line. A second case is an enable-set arriving in the same cycle as the rising line of a level source. Directed steps force both collisions on purpose. The random phase then draws ids from a small pool so that such overlaps happen often. Every cycle, the pending matrix, enable vector and update pulse are compared against a bench model in which every set term is applied after the clear terms.

// File: rtl/irqtrk_pkg.sv
// Package: shared constants and the per-source strobe bundle for the
// interrupt source pending tracker.
// Assumes: id map with 32 internal ids before the first line-driven id.
package irqtrk_pkg;

    localparam int LINE_BASE   = 32;  // first id driven by an external line
    localparam int PRIV_LIMIT  = 32;  // ids below this are per-CPU
    localparam int FIXED_LIMIT = 16;  // ids below this cannot be disabled

    // strobe kinds, used as index into the decoded hit array
    localparam int K_EN_SET = 0;
    localparam int K_EN_CLR = 1;
    localparam int K_CFG    = 2;
    localparam int K_TGT    = 3;
    localparam int K_PSET   = 4;
    localparam int K_PCLR   = 5;
    localparam int K_ACK    = 6;
    localparam int K_EOI    = 7;
    localparam int NUM_KINDS = 8;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic cfg;
        logic tgt;
        logic pset;
        logic pclr;
        logic ack;
        logic eoi;
    } src_hits_t;

endpackage

// File: rtl/irqtrk_dec.sv
// Module: one-hot decoder for an index qualified by a valid strobe.
// Assumes: indexes at or above N simply produce no hit.
module irqtrk_dec #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic         vld,
    input  logic [W-1:0] idx,
    output logic [N-1:0] oh
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    // decode the index into a one-hot vector when valid
    always_comb begin
        oh = vld ? (ONE << idx) : '0;
    end

endmodule

// File: rtl/irqtrk_cell.sv
// Module: state of one interrupt source. Holds enable, trigger, model,
// target mask, line level and per-CPU pending, and merges all strobes
// addressed to this id in one cycle with sets taking precedence.
// Assumes: CPU one-hot inputs carry exactly one bit; line is tied low for
// ids without an external line.
module irqtrk_cell
    import irqtrk_pkg::*;
#(
    parameter int ID      = 0,
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line,
    input  src_hits_t          hit,
    input  logic               cfg_edge,
    input  logic               cfg_model,
    input  logic [NUM_CPU-1:0] tgt_mask,
    input  logic [NUM_CPU-1:0] wr_cpu_oh,
    input  logic [NUM_CPU-1:0] ack_cpu_oh,
    input  logic [NUM_CPU-1:0] eoi_cpu_oh,
    output logic [NUM_CPU-1:0] pend,
    output logic               en,
    output logic               chg
);

    localparam bit HAS_LINE = (ID >= LINE_BASE);
    localparam bit PRIV     = (ID < PRIV_LIMIT);
    localparam bit FIXED    = (ID < FIXED_LIMIT);
    localparam logic [NUM_CPU-1:0] ALL = '1;

    logic               en_r, edge_r, model_r, lvl_r;
    logic [NUM_CPU-1:0] tgt_r, pend_r;
    logic               en_n, edge_n, model_n, lvl_n;
    logic [NUM_CPU-1:0] tgt_n, pend_n;
    logic               rise;
    logic [NUM_CPU-1:0] own_mask, set_m, clr_m;

    // next-state of the configuration bits and the line level
    always_comb begin
        lvl_n   = HAS_LINE ? line : 1'b0;
        rise    = HAS_LINE && line && !lvl_r;
        en_n    = hit.en_set | (en_r & ~(hit.en_clr & ~FIXED));
        edge_n  = hit.cfg ? cfg_edge  : edge_r;
        model_n = hit.cfg ? cfg_model : model_r;
        tgt_n   = hit.tgt ? tgt_mask  : tgt_r;
    end

    // next-state of pending: clear terms first, set terms on top
    always_comb begin
        own_mask = PRIV ? wr_cpu_oh : tgt_r;
        set_m = '0;
        if (rise && (edge_r || en_r))
            set_m = set_m | tgt_r;
        if (hit.en_set && lvl_n && !edge_r)
            set_m = set_m | own_mask;
        if (hit.eoi && !edge_r && en_r && lvl_r)
            set_m = set_m | (eoi_cpu_oh & tgt_r);
        if (hit.pset)
            set_m = set_m | own_mask;
        clr_m = '0;
        if (hit.ack)
            clr_m = clr_m | (model_r ? ALL : ack_cpu_oh);
        if (hit.pclr)
            clr_m = ALL;
        pend_n = (pend_r & ~clr_m) | set_m;
    end

    // flag any difference between current and next state
    always_comb begin
        chg = {en_n, edge_n, model_n, lvl_n, tgt_n, pend_n}
           != {en_r, edge_r, model_r, lvl_r, tgt_r, pend_r};
    end

    // state registers with the reset pattern of this id
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_r    <= FIXED;
            edge_r  <= FIXED;
            model_r <= 1'b0;
            lvl_r   <= 1'b0;
            tgt_r   <= '0;
            pend_r  <= '0;
        end else begin
            en_r    <= en_n;
            edge_r  <= edge_n;
            model_r <= model_n;
            lvl_r   <= lvl_n;
            tgt_r   <= tgt_n;
            pend_r  <= pend_n;
        end
    end

    assign pend = pend_r;
    assign en   = en_r;

    // R2: an unchanged line with no strobe leaves the source untouched
    p_ignore_same_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line == lvl_r && hit == '0)
        |=> ($stable(pend_r) && $stable(lvl_r) && $stable(en_r)));

    // R4: a falling line keeps pending when nothing else sets or clears it
    p_fall_keeps_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_r && !line && !hit.pset && !hit.pclr && !hit.ack && !hit.eoi && !hit.en_set)
        |=> ($stable(pend_r) && !lvl_r));

    // R6: one-of-N acknowledge clears all CPUs when no set competes
    p_ack_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.ack && model_r && !hit.pset && !hit.en_set && !hit.eoi && !(line && !lvl_r))
        |=> (pend_r == '0));

    // R6: each-of-N acknowledge clears the acknowledging CPU
    p_ack_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.ack && !model_r && !hit.pset && !hit.en_set && !hit.eoi && !(line && !lvl_r))
        |=> ((pend_r & $past(ack_cpu_oh)) == '0));

    // R10: enable set wins over a simultaneous enable clear
    p_enable_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.en_set && hit.en_clr) |=> en_r);

    generate
        if (FIXED) begin : g_fixed_chk
            // R9: low ids stay enabled through an enable clear
            p_fixed_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                hit.en_clr |=> en_r);
        end
    endgenerate

endmodule

// File: rtl/irq_pend_tracker.sv
// Module: top of the interrupt source pending tracker. Decodes every
// strobe into a per-id hit, instantiates one state cell per source, and
// drives the pending matrix, the enable vector and a registered change pulse.
// Assumes: at most one strobe of each kind per cycle; NUM_SRC > 32.
module irq_pend_tracker
    import irqtrk_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_SRC = 64,
    localparam int ID_W     = $clog2(NUM_SRC),
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_LINE = NUM_SRC - LINE_BASE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINE-1:0]        ext_line,
    input  logic [CPU_W-1:0]           wr_cpu,
    input  logic                       en_set_vld,
    input  logic [ID_W-1:0]            en_set_id,
    input  logic                       en_clr_vld,
    input  logic [ID_W-1:0]            en_clr_id,
    input  logic                       cfg_vld,
    input  logic [ID_W-1:0]            cfg_id,
    input  logic                       cfg_edge,
    input  logic                       cfg_model,
    input  logic                       tgt_vld,
    input  logic [ID_W-1:0]            tgt_id,
    input  logic [NUM_CPU-1:0]         tgt_mask,
    input  logic                       pset_vld,
    input  logic [ID_W-1:0]            pset_id,
    input  logic                       pclr_vld,
    input  logic [ID_W-1:0]            pclr_id,
    input  logic                       ack_vld,
    input  logic [ID_W-1:0]            ack_id,
    input  logic [CPU_W-1:0]           ack_cpu,
    input  logic                       eoi_vld,
    input  logic [ID_W-1:0]            eoi_id,
    input  logic [CPU_W-1:0]           eoi_cpu,
    output logic [NUM_CPU*NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0]         en_o,
    output logic                       upd_o
);

    logic [NUM_KINDS-1:0]  kind_vld;
    logic [ID_W-1:0]       kind_id  [NUM_KINDS];
    logic [NUM_SRC-1:0]    kind_oh  [NUM_KINDS];
    logic [NUM_CPU-1:0]    wr_oh, ack_oh, eoi_oh;
    logic [NUM_SRC-1:0]    line_w;
    logic [NUM_CPU-1:0]    pend_w   [NUM_SRC];
    logic [NUM_SRC-1:0]    chg_w;
    logic                  upd_r;

    // gather the strobes into arrays indexed by kind
    always_comb begin
        kind_vld[K_EN_SET] = en_set_vld;  kind_id[K_EN_SET] = en_set_id;
        kind_vld[K_EN_CLR] = en_clr_vld;  kind_id[K_EN_CLR] = en_clr_id;
        kind_vld[K_CFG]    = cfg_vld;     kind_id[K_CFG]    = cfg_id;
        kind_vld[K_TGT]    = tgt_vld;     kind_id[K_TGT]    = tgt_id;
        kind_vld[K_PSET]   = pset_vld;    kind_id[K_PSET]   = pset_id;
        kind_vld[K_PCLR]   = pclr_vld;    kind_id[K_PCLR]   = pclr_id;
        kind_vld[K_ACK]    = ack_vld;     kind_id[K_ACK]    = ack_id;
        kind_vld[K_EOI]    = eoi_vld;     kind_id[K_EOI]    = eoi_id;
    end

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            irqtrk_dec #(.N(NUM_SRC), .W(ID_W)) u_dec (
                .vld (kind_vld[k]),
                .idx (kind_id[k]),
                .oh  (kind_oh[k])
            );
        end
    endgenerate

    irqtrk_dec #(.N(NUM_CPU), .W(CPU_W)) u_wr_dec  (.vld(1'b1), .idx(wr_cpu),  .oh(wr_oh));
    irqtrk_dec #(.N(NUM_CPU), .W(CPU_W)) u_ack_dec (.vld(1'b1), .idx(ack_cpu), .oh(ack_oh));
    irqtrk_dec #(.N(NUM_CPU), .W(CPU_W)) u_eoi_dec (.vld(1'b1), .idx(eoi_cpu), .oh(eoi_oh));

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            src_hits_t hits;

            // collect this id's hit from every strobe kind
            always_comb begin
                hits.en_set = kind_oh[K_EN_SET][g];
                hits.en_clr = kind_oh[K_EN_CLR][g];
                hits.cfg    = kind_oh[K_CFG][g];
                hits.tgt    = kind_oh[K_TGT][g];
                hits.pset   = kind_oh[K_PSET][g];
                hits.pclr   = kind_oh[K_PCLR][g];
                hits.ack    = kind_oh[K_ACK][g];
                hits.eoi    = kind_oh[K_EOI][g];
            end

            if (g >= LINE_BASE) begin : g_line
                assign line_w[g] = ext_line[g-LINE_BASE];
            end else begin : g_noline
                assign line_w[g] = 1'b0;
            end

            irqtrk_cell #(.ID(g), .NUM_CPU(NUM_CPU)) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .line       (line_w[g]),
                .hit        (hits),
                .cfg_edge   (cfg_edge),
                .cfg_model  (cfg_model),
                .tgt_mask   (tgt_mask),
                .wr_cpu_oh  (wr_oh),
                .ack_cpu_oh (ack_oh),
                .eoi_cpu_oh (eoi_oh),
                .pend       (pend_w[g]),
                .en         (en_o[g]),
                .chg        (chg_w[g])
            );

            for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
                assign pend_o[c*NUM_SRC+g] = pend_w[g][c];
            end
        end
    endgenerate

    // register the change pulse so it lines up with the new state
    always_ff @(posedge clk) begin
        if (!rst_n) upd_r <= 1'b0;
        else        upd_r <= |chg_w;
    end

    assign upd_o = upd_r;

    // R11: any visible change of pending or enable comes with the pulse
    p_update_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pend_o) || !$stable(en_o)) |-> upd_o);

endmodule

// File: tb/irq_pend_tracker_test.sv
`timescale 1ns/1ps
module irq_pend_tracker_test;

    localparam int NS = 64;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] ext_line = '0;
    logic wr_cpu, en_set_vld, en_clr_vld, cfg_vld, cfg_edge, cfg_model;
    logic tgt_vld, pset_vld, pclr_vld, ack_vld, ack_cpu, eoi_vld, eoi_cpu;
    logic [5:0] en_set_id, en_clr_id, cfg_id, tgt_id, pset_id, pclr_id, ack_id, eoi_id;
    logic [1:0] tgt_mask;
    logic [NC*NS-1:0] pend_o;
    logic [NS-1:0] en_o;
    logic upd_o;

    int total = 0;
    int bad = 0;

    bit       m_en [NS], m_edge [NS], m_model [NS], m_lvl [NS];
    bit [1:0] m_tgt [NS], m_pend [NS];
    bit       m_upd;

    always #4 clk = ~clk;

    irq_pend_tracker #(.NUM_CPU(NC), .NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .wr_cpu(wr_cpu),
        .en_set_vld(en_set_vld), .en_set_id(en_set_id),
        .en_clr_vld(en_clr_vld), .en_clr_id(en_clr_id),
        .cfg_vld(cfg_vld), .cfg_id(cfg_id), .cfg_edge(cfg_edge), .cfg_model(cfg_model),
        .tgt_vld(tgt_vld), .tgt_id(tgt_id), .tgt_mask(tgt_mask),
        .pset_vld(pset_vld), .pset_id(pset_id), .pclr_vld(pclr_vld), .pclr_id(pclr_id),
        .ack_vld(ack_vld), .ack_id(ack_id), .ack_cpu(ack_cpu),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .eoi_cpu(eoi_cpu),
        .pend_o(pend_o), .en_o(en_o), .upd_o(upd_o)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_cpu = 0; en_set_vld = 0; en_clr_vld = 0; cfg_vld = 0; cfg_edge = 0;
        cfg_model = 0; tgt_vld = 0; pset_vld = 0; pclr_vld = 0; ack_vld = 0;
        ack_cpu = 0; eoi_vld = 0; eoi_cpu = 0; tgt_mask = 0;
        en_set_id = 0; en_clr_id = 0; cfg_id = 0; tgt_id = 0;
        pset_id = 0; pclr_id = 0; ack_id = 0; eoi_id = 0;
    endtask

    // reset contents of the model, from R8
    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_en[i] = (i < 16); m_edge[i] = (i < 16); m_model[i] = 0;
            m_lvl[i] = 0; m_tgt[i] = 0; m_pend[i] = 0;
        end
        m_upd = 0;
    endtask

    // expected next state from the driven inputs, built from R1 to R13
    task automatic model_step();
        bit chg_any = 0;
        for (int i = 0; i < NS; i++) begin
            bit line, rise, lvl_n, en_n, es, ec;
            bit [1:0] own, setm, clrm, pend_n, tgt_n;
            bit edge_n, model_n;
            line  = (i >= 32) ? ext_line[i-32] : 1'b0;
            rise  = line && !m_lvl[i];
            lvl_n = line;
            es = en_set_vld && en_set_id == i;
            ec = en_clr_vld && en_clr_id == i && i >= 16;
            en_n = es || (m_en[i] && !ec);
            own = (i < 32) ? (2'b01 << wr_cpu) : m_tgt[i];
            setm = 0; clrm = 0;
            if (rise && (m_edge[i] || m_en[i])) setm |= m_tgt[i];
            if (es && lvl_n && !m_edge[i]) setm |= own;
            if (eoi_vld && eoi_id == i && !m_edge[i] && m_en[i] && m_lvl[i])
                setm |= (2'b01 << eoi_cpu) & m_tgt[i];
            if (pset_vld && pset_id == i) setm |= own;
            if (ack_vld && ack_id == i) clrm |= m_model[i] ? 2'b11 : (2'b01 << ack_cpu);
            if (pclr_vld && pclr_id == i) clrm = 2'b11;
            pend_n  = (m_pend[i] & ~clrm) | setm;
            edge_n  = (cfg_vld && cfg_id == i) ? cfg_edge  : m_edge[i];
            model_n = (cfg_vld && cfg_id == i) ? cfg_model : m_model[i];
            tgt_n   = (tgt_vld && tgt_id == i) ? tgt_mask  : m_tgt[i];
            if (pend_n != m_pend[i] || en_n != m_en[i] || edge_n != m_edge[i] ||
                model_n != m_model[i] || lvl_n != m_lvl[i] || tgt_n != m_tgt[i])
                chg_any = 1;
            m_pend[i] = pend_n; m_en[i] = en_n; m_edge[i] = edge_n;
            m_model[i] = model_n; m_lvl[i] = lvl_n; m_tgt[i] = tgt_n;
        end
        m_upd = chg_any;
    endtask

    task automatic compare_model(string tag);
        logic [127:0] ep, ee;
        ep = '0; ee = '0;
        for (int i = 0; i < NS; i++) begin
            ee[i] = m_en[i];
            for (int c = 0; c < NC; c++) ep[c*NS+i] = m_pend[i][c];
        end
        chg({tag, " pend"}, {{(128-NC*NS){1'b0}}, pend_o}, ep);
        chg_en(tag, en_o, ee[NS-1:0]);
        chk({tag, " upd R11"}, {127'b0, upd_o}, {127'b0, m_upd});
    endtask

    task automatic chg(string tag, logic [127:0] act, logic [127:0] exp);
        chk(tag, act, exp);
    endtask

    task automatic chg_en(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
        chk({tag, " en"}, {64'b0, act}, {64'b0, exp});
    endtask

    // apply one cycle of stimulus and compare every output with the model
    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        #2;
        compare_model(tag);
        idle();
    endtask

    function automatic logic [5:0] pick();
        case ($urandom % 12)
            0: return 6'd0;   1: return 6'd3;   2: return 6'd15;  3: return 6'd16;
            4: return 6'd20;  5: return 6'd31;  6: return 6'd32;  7: return 6'd33;
            8: return 6'd34;  9: return 6'd35;  10: return 6'd39; default: return 6'd63;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        model_reset();
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        // R8: reset pattern
        chk("R8 en after reset", {64'b0, en_o}, {64'b0, 64'h0000_0000_0000_FFFF});
        chk("R8 pend after reset", {{(128-NC*NS){1'b0}}, pend_o}, 128'b0);
        chk("R8 upd after reset", {127'b0, upd_o}, 128'b0);

        // R13: target of id 33 = CPU1 only
        tgt_vld = 1; tgt_id = 33; tgt_mask = 2'b10; tick("R13 tgt");
        // R1 R3: line 1 rises on disabled level source 33, no pending
        ext_line[1] = 1; tick("R3 rise disabled");
        chk("R3 no pend on disabled level", {127'b0, pend_o[64+33] | pend_o[33]}, 128'b0);
        // R2: unchanged line, nothing happens
        tick("R2 idle");
        chk("R2 no update", {127'b0, upd_o}, 128'b0);
        // R5: enable while high marks the target mask, not the writer
        en_set_vld = 1; en_set_id = 33; wr_cpu = 0; tick("R5 enable");
        chk("R5 target cpu1", {126'b0, pend_o[64+33], pend_o[33]}, 128'b10);
        // R6: each-of-N ack from CPU1 clears it
        ack_vld = 1; ack_id = 33; ack_cpu = 1; tick("R6 ack own");
        chk("R6 cleared cpu1", {127'b0, pend_o[64+33]}, 128'b0);
        // R12: software set on both targets
        tgt_vld = 1; tgt_id = 33; tgt_mask = 2'b11; tick("R13 tgt both");
        pset_vld = 1; pset_id = 33; tick("R12 pset");
        chk("R12 both set", {126'b0, pend_o[64+33], pend_o[33]}, 128'b11);
        ack_vld = 1; ack_id = 33; ack_cpu = 0; tick("R6 ack cpu0");
        chk("R6 only cpu0 cleared", {126'b0, pend_o[64+33], pend_o[33]}, 128'b10);
        // R7: end of interrupt while still high re-marks CPU0
        eoi_vld = 1; eoi_id = 33; eoi_cpu = 0; tick("R7 eoi");
        chk("R7 remark cpu0", {127'b0, pend_o[33]}, 128'b1);
        // R4: falling line keeps pending
        ext_line[1] = 0; tick("R4 fall");
        chk("R4 pend kept", {126'b0, pend_o[64+33], pend_o[33]}, 128'b11);
        // R6: one-of-N ack clears every CPU
        cfg_vld = 1; cfg_id = 33; cfg_edge = 0; cfg_model = 1; tick("R13 cfg");
        ack_vld = 1; ack_id = 33; ack_cpu = 0; tick("R6 ack all");
        chk("R6 all cleared", {126'b0, pend_o[64+33], pend_o[33]}, 128'b0);
        // R10: set against clear in one cycle
        tgt_vld = 1; tgt_id = 40; tgt_mask = 2'b01; tick("R13 tgt40");
        pset_vld = 1; pset_id = 40; pclr_vld = 1; pclr_id = 40;
        en_set_vld = 1; en_set_id = 40; en_clr_vld = 1; en_clr_id = 40; tick("R10 collide");
        chk("R10 pend set wins", {127'b0, pend_o[40]}, 128'b1);
        chk("R10 enable set wins", {127'b0, en_o[40]}, 128'b1);
        // R10: ack and software set together on id 33
        pset_vld = 1; pset_id = 33; ack_vld = 1; ack_id = 33; ack_cpu = 1; tick("R10 ack vs set");
        chk("R10 set beats ack", {126'b0, pend_o[64+33], pend_o[33]}, 128'b11);
        // R9: low id cannot be disabled
        en_clr_vld = 1; en_clr_id = 3; tick("R9 clr low");
        chk("R9 id3 enabled", {127'b0, en_o[3]}, 128'b1);
        // R12: private id uses the writing CPU
        pset_vld = 1; pset_id = 20; wr_cpu = 1; tick("R12 private");
        chk("R12 private writer", {126'b0, pend_o[64+20], pend_o[20]}, 128'b10);
        // R3: edge source marks pending even when disabled
        cfg_vld = 1; cfg_id = 34; cfg_edge = 1; cfg_model = 0; tick("R13 cfg34");
        tgt_vld = 1; tgt_id = 34; tgt_mask = 2'b01; tick("R13 tgt34");
        ext_line[2] = 1; tick("R3 edge rise");
        chk("R3 edge pending", {127'b0, pend_o[34]}, 128'b1);
        // R5: enable set and rise in one cycle on a level source
        tgt_vld = 1; tgt_id = 35; tgt_mask = 2'b10; tick("R13 tgt35");
        ext_line[3] = 1; en_set_vld = 1; en_set_id = 35; tick("R5 rise with enable");
        chk("R5 same-cycle enable", {127'b0, pend_o[64+35]}, 128'b1);

        // random phase over a small id pool
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 2 == 0) ext_line[$urandom % 8] = ~ext_line[$urandom % 8];
            wr_cpu  = $urandom % 2; ack_cpu = $urandom % 2; eoi_cpu = $urandom % 2;
            en_set_vld = ($urandom % 4 == 0); en_set_id = pick();
            en_clr_vld = ($urandom % 4 == 0); en_clr_id = pick();
            cfg_vld = ($urandom % 6 == 0); cfg_id = pick();
            cfg_edge = $urandom % 2; cfg_model = $urandom % 2;
            tgt_vld = ($urandom % 5 == 0); tgt_id = pick(); tgt_mask = $urandom % 4;
            pset_vld = ($urandom % 4 == 0); pset_id = pick();
            pclr_vld = ($urandom % 5 == 0); pclr_id = pick();
            ack_vld = ($urandom % 3 == 0); ack_id = pick();
            eoi_vld = ($urandom % 3 == 0); eoi_id = pick();
            tick("random R3 R5 R6 R7 R10 R12");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule